// File: doc/BRIEF.md
# Cipher Engine Control Register File with Ownership Arbiter

This block is an APB slave that holds the configuration of a cryptographic engine and decides which of two masters may use it: the processor subsystem (through APB writes) or the programmable fabric (through two dedicated inputs). It has three 32-bit word registers: a control word, a stall seed and an upper-address register. The control word drives the engine's reset, purge, go, oscillator enable, stream enable, stall enable, stall rate and fabric clock select. It also returns engine status and ownership state.

Ownership is a three-state arbiter: free, held by the processor, or held by the fabric. The processor requests and releases with write-only pulse bits in the control word. The fabric uses level inputs that are sampled every clock. The upper-address register supplies six bits that are placed above the engine's 32-bit master address, which gives a 38-bit system address.

Top module: `cipher_ctrl_regfile`

## Requirements
- R1: After reset the control word (offset 0x00) reads 0x00000001, with `eng_rst` high and every other control output low. The seed (0x04) and upper-address (0x08) registers read zero. Neither owner flag is set.
- R2: A control write stores bit 0 (`eng_rst`), bit 1 (`eng_purge`), bit 2 (`eng_go`), bit 3 (`osc_on`), bit 4 (`stream_en`), bit 5 (`stall_en`), bits 7:6 (`stall_rate`) and bit 16 (`fab_clk_sel`). The matching outputs follow from the clock edge of the access phase, and the same bits read back.
- R3: Control bits 8..12 read the live inputs `eng_done`, `eng_alarm`, `eng_bus_err`, `eng_stream_act` and `eng_busy`, in that order. Writes do not alter them. Bits 15:13, 23:17 and 31:30 always read zero.
- R4: The seed register at 0x04 stores all 32 written bits and drives `stall_seed`.
- R5: The upper-address register at 0x08 stores bits 5:0 and reads zero above them. `master_addr` equals {upper bits, `eng_addr`}.
- R6: While the engine is free, a request from either side is granted at the next clock edge. A processor request is control bit 24 in a write. A fabric request is `fab_req` high. When both request in the same cycle, the processor wins.
- R7: A release from the current owner returns the state to free. A processor release is control bit 25 in a write. A fabric release is `fab_rel` high. A release from the non-owner is ignored, and so is a request while the engine is owned.
- R8: `own_cpu` and `own_fab` are never both high and read back at control bits 28 and 29. Bits 26 and 27 read the live `fab_req` and `fab_rel`. Bits 24 and 25 always read zero.
- R9: `pready` is always high and `pslverr` always low. An access to an offset other than 0x00, 0x04 or 0x08, or one with `paddr[1:0]` nonzero, reads zero and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, zero when not selected |
| pready | output | 1 | Always high |
| pslverr | output | 1 | Always low |
| eng_done | input | 1 | Engine completion status |
| eng_alarm | input | 1 | Engine alarm status |
| eng_bus_err | input | 1 | Engine bus-error status |
| eng_stream_act | input | 1 | Streaming path active status |
| eng_busy | input | 1 | Engine busy status |
| fab_req | input | 1 | Fabric ownership request |
| fab_rel | input | 1 | Fabric ownership release |
| eng_addr | input | LO_W | Engine master address, low part |
| eng_rst | output | 1 | Engine reset |
| eng_purge | output | 1 | Engine purge command |
| eng_go | output | 1 | Engine go command |
| osc_on | output | 1 | Oscillator enable |
| stream_en | output | 1 | Streaming interface enable |
| stall_en | output | 1 | Internal stall mode enable |
| stall_rate | output | 2 | Average stall rate code |
| fab_clk_sel | output | 1 | Use the fabric clock while the processor owns the engine |
| stall_seed | output | 32 | Seed for the stall generator |
| master_addr | output | HI_W+LO_W | Widened engine master address |
| own_cpu | output | 1 | Processor owns the engine |
| own_fab | output | 1 | Fabric owns the engine |

## Verification
The hardest case to reach from the ports is a processor write whose request and release bits land in the same clock as particular fabric request and release levels. It must also land while the arbiter is already in a chosen state. The bench first drives the arbiter into free, processor-owned or fabric-owned with single-purpose writes and fabric pulses. It then issues one write that carries every combination of the two processor bits and holds the two fabric inputs exactly during that access phase. Each of the 48 outcomes is compared against a next-state rule computed in the bench.

// File: rtl/ccr_pkg.sv
// Package: shared constants and types for the cipher control register file.
// Assumes 32-bit APB data and word-aligned registers.
package ccr_pkg;
    localparam int unsigned REG_W   = 32;
    localparam int unsigned NUM_REG = 3;

    // Register word indices (byte offset = index * 4)
    localparam int unsigned IDX_CTRL = 0;
    localparam int unsigned IDX_SEED = 1;
    localparam int unsigned IDX_HI   = 2;

    // Control word bit positions
    localparam int unsigned B_RST      = 0;
    localparam int unsigned B_PURGE    = 1;
    localparam int unsigned B_GO       = 2;
    localparam int unsigned B_OSC      = 3;
    localparam int unsigned B_STREAM   = 4;
    localparam int unsigned B_STALL    = 5;
    localparam int unsigned B_RATE_LO  = 6;
    localparam int unsigned B_RATE_HI  = 7;
    localparam int unsigned B_DONE     = 8;
    localparam int unsigned B_ALARM    = 9;
    localparam int unsigned B_BUSERR   = 10;
    localparam int unsigned B_STRACT   = 11;
    localparam int unsigned B_BUSY     = 12;
    localparam int unsigned B_FABCLK   = 16;
    localparam int unsigned B_CPU_REQ  = 24;
    localparam int unsigned B_CPU_REL  = 25;
    localparam int unsigned B_FAB_REQ  = 26;
    localparam int unsigned B_FAB_REL  = 27;
    localparam int unsigned B_OWN_CPU  = 28;
    localparam int unsigned B_OWN_FAB  = 29;

    typedef enum logic [1:0] {
        OWN_FREE = 2'd0,
        OWN_CPU  = 2'd1,
        OWN_FAB  = 2'd2
    } own_state_t;

    typedef struct packed {
        logic       fab_clk;
        logic [1:0] rate;
        logic       stall;
        logic       stream;
        logic       osc;
        logic       go;
        logic       purge;
        logic       rst;
    } ctrl_t;
endpackage

// File: rtl/ccr_apb_decode.sv
// Module: APB address decode. Produces a one-hot register hit for aligned
// accesses and a write strobe asserted in the access phase of a write.
// Assumes registers occupy consecutive words starting at offset 0.
module ccr_apb_decode #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned NREG   = 3
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output logic [NREG-1:0]   reg_hit,
    output logic [NREG-1:0]   reg_wr
);
    localparam int unsigned WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word_idx;
    logic              aligned;
    logic              wr_access;

    // Split the byte address into a word index and an alignment check
    assign word_idx  = paddr[ADDR_W-1:2];
    assign aligned   = (paddr[1:0] == 2'b00);
    assign wr_access = psel & penable & pwrite;

    // One comparator per register word
    generate
        for (genvar i = 0; i < NREG; i++) begin : g_hit
            assign reg_hit[i] = aligned && (word_idx == WORD_W'(i));
            assign reg_wr[i]  = wr_access & reg_hit[i];
        end
    endgenerate
endmodule

// File: rtl/ccr_cfg_store.sv
// Module: storage for the writable configuration fields (control fields,
// stall seed, upper address bits). Assumes one write strobe per register.
module ccr_cfg_store
    import ccr_pkg::*;
#(
    parameter int unsigned HI_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl,
    input  logic             wr_seed,
    input  logic             wr_hi,
    input  logic [REG_W-1:0] wdata,
    output ctrl_t            ctrl,
    output logic [REG_W-1:0] seed,
    output logic [HI_W-1:0]  hi_addr
);
    // Control fields: engine reset starts asserted, the rest start clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl     <= '0;
            ctrl.rst <= 1'b1;
        end else if (wr_ctrl) begin
            ctrl.rst     <= wdata[B_RST];
            ctrl.purge   <= wdata[B_PURGE];
            ctrl.go      <= wdata[B_GO];
            ctrl.osc     <= wdata[B_OSC];
            ctrl.stream  <= wdata[B_STREAM];
            ctrl.stall   <= wdata[B_STALL];
            ctrl.rate    <= wdata[B_RATE_HI:B_RATE_LO];
            ctrl.fab_clk <= wdata[B_FABCLK];
        end
    end

    // Stall seed: full-width register
    always_ff @(posedge clk) begin
        if (!rst_n)       seed <= '0;
        else if (wr_seed) seed <= wdata;
    end

    // Upper address bits: only the low HI_W bits are kept
    always_ff @(posedge clk) begin
        if (!rst_n)     hi_addr <= '0;
        else if (wr_hi) hi_addr <= wdata[HI_W-1:0];
    end

    assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (ctrl.rst == $past(wdata[B_RST])) &&
                    (ctrl.rate == $past(wdata[B_RATE_HI:B_RATE_LO])));

    assert_seed_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_seed |=> $stable(seed));
endmodule

// File: rtl/ccr_owner_fsm.sv
// Module: three-state ownership arbiter (free / processor / fabric).
// Assumes request and release inputs are sampled on every clock edge.
// Processor has priority when both sides request in the same cycle.
module ccr_owner_fsm
    import ccr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_req,
    input  logic cpu_rel,
    input  logic fab_req,
    input  logic fab_rel,
    output logic own_cpu,
    output logic own_fab
);
    own_state_t state, state_nx;

    // Next-state rule: grant from free, release only by the holder
    always_comb begin
        state_nx = state;
        unique case (state)
            OWN_FREE: begin
                if (cpu_req)      state_nx = OWN_CPU;
                else if (fab_req) state_nx = OWN_FAB;
            end
            OWN_CPU:  if (cpu_rel) state_nx = OWN_FREE;
            OWN_FAB:  if (fab_rel) state_nx = OWN_FREE;
            default:  state_nx = OWN_FREE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= OWN_FREE;
        else        state <= state_nx;
    end

    assign own_cpu = (state == OWN_CPU);
    assign own_fab = (state == OWN_FAB);

    assert_owner_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(own_cpu && own_fab));

    assert_cpu_priority_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!own_cpu && !own_fab && cpu_req) |=> own_cpu);

    assert_fab_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!own_cpu && !own_fab && !cpu_req && fab_req) |=> own_fab);

    assert_cpu_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (own_cpu && !cpu_rel) |=> own_cpu);

    assert_fab_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (own_fab && !fab_rel) |=> own_fab);

    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((own_cpu && cpu_rel) || (own_fab && fab_rel)) |=> (!own_cpu && !own_fab));
endmodule

// File: rtl/cipher_ctrl_regfile.sv
// Module: top of the cipher engine control register file. Connects the APB
// decode, configuration storage and ownership arbiter, builds the read word
// and widens the engine master address. Assumes a zero-wait-state APB.
module cipher_ctrl_regfile
    import ccr_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned HI_W   = 6,
    parameter int unsigned LO_W   = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 psel,
    input  logic                 penable,
    input  logic                 pwrite,
    input  logic [ADDR_W-1:0]    paddr,
    input  logic [REG_W-1:0]     pwdata,
    output logic [REG_W-1:0]     prdata,
    output logic                 pready,
    output logic                 pslverr,
    input  logic                 eng_done,
    input  logic                 eng_alarm,
    input  logic                 eng_bus_err,
    input  logic                 eng_stream_act,
    input  logic                 eng_busy,
    input  logic                 fab_req,
    input  logic                 fab_rel,
    input  logic [LO_W-1:0]      eng_addr,
    output logic                 eng_rst,
    output logic                 eng_purge,
    output logic                 eng_go,
    output logic                 osc_on,
    output logic                 stream_en,
    output logic                 stall_en,
    output logic [1:0]           stall_rate,
    output logic                 fab_clk_sel,
    output logic [REG_W-1:0]     stall_seed,
    output logic [HI_W+LO_W-1:0] master_addr,
    output logic                 own_cpu,
    output logic                 own_fab
);
    logic [NUM_REG-1:0] reg_hit;
    logic [NUM_REG-1:0] reg_wr;
    ctrl_t              ctrl;
    logic [HI_W-1:0]    hi_addr;
    logic               cpu_req_p;
    logic               cpu_rel_p;
    logic [REG_W-1:0]   ctrl_word;
    logic [REG_W-1:0]   rd_word;

    ccr_apb_decode #(.ADDR_W(ADDR_W), .NREG(NUM_REG)) u_dec (
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .reg_hit (reg_hit),
        .reg_wr  (reg_wr)
    );

    ccr_cfg_store #(.HI_W(HI_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (reg_wr[IDX_CTRL]),
        .wr_seed (reg_wr[IDX_SEED]),
        .wr_hi   (reg_wr[IDX_HI]),
        .wdata   (pwdata),
        .ctrl    (ctrl),
        .seed    (stall_seed),
        .hi_addr (hi_addr)
    );

    // Processor request/release exist only as one-cycle write pulses
    assign cpu_req_p = reg_wr[IDX_CTRL] & pwdata[B_CPU_REQ];
    assign cpu_rel_p = reg_wr[IDX_CTRL] & pwdata[B_CPU_REL];

    ccr_owner_fsm u_own (
        .clk     (clk),
        .rst_n   (rst_n),
        .cpu_req (cpu_req_p),
        .cpu_rel (cpu_rel_p),
        .fab_req (fab_req),
        .fab_rel (fab_rel),
        .own_cpu (own_cpu),
        .own_fab (own_fab)
    );

    // Engine control outputs straight from the stored fields
    assign eng_rst     = ctrl.rst;
    assign eng_purge   = ctrl.purge;
    assign eng_go      = ctrl.go;
    assign osc_on      = ctrl.osc;
    assign stream_en   = ctrl.stream;
    assign stall_en    = ctrl.stall;
    assign stall_rate  = ctrl.rate;
    assign fab_clk_sel = ctrl.fab_clk;

    // Widened master address: stored upper bits above the engine address
    assign master_addr = {hi_addr, eng_addr};

    // Zero-wait, error-free bus responses
    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    // Assemble the control read word; reserved and pulse bits stay zero
    always_comb begin
        ctrl_word                        = '0;
        ctrl_word[B_RST]                 = ctrl.rst;
        ctrl_word[B_PURGE]               = ctrl.purge;
        ctrl_word[B_GO]                  = ctrl.go;
        ctrl_word[B_OSC]                 = ctrl.osc;
        ctrl_word[B_STREAM]              = ctrl.stream;
        ctrl_word[B_STALL]               = ctrl.stall;
        ctrl_word[B_RATE_HI:B_RATE_LO]   = ctrl.rate;
        ctrl_word[B_DONE]                = eng_done;
        ctrl_word[B_ALARM]               = eng_alarm;
        ctrl_word[B_BUSERR]              = eng_bus_err;
        ctrl_word[B_STRACT]              = eng_stream_act;
        ctrl_word[B_BUSY]                = eng_busy;
        ctrl_word[B_FABCLK]              = ctrl.fab_clk;
        ctrl_word[B_FAB_REQ]             = fab_req;
        ctrl_word[B_FAB_REL]             = fab_rel;
        ctrl_word[B_OWN_CPU]             = own_cpu;
        ctrl_word[B_OWN_FAB]             = own_fab;
    end

    // Read multiplexer driven by the one-hot register hit
    always_comb begin
        rd_word = '0;
        if (reg_hit[IDX_CTRL]) rd_word = ctrl_word;
        if (reg_hit[IDX_SEED]) rd_word = stall_seed;
        if (reg_hit[IDX_HI])   rd_word = REG_W'(hi_addr);
        prdata = psel ? rd_word : '0;
    end

    assert_hit_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_hit));

    assert_unmapped_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && pwrite && (reg_hit == '0)) |=>
            ($stable(stall_seed) && $stable(hi_addr) && $stable(ctrl)));

    assert_pulse_bits_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && reg_hit[IDX_CTRL]) |-> (prdata[B_CPU_REQ] == 1'b0 && prdata[B_CPU_REL] == 1'b0));

    assert_hi_readback_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && reg_hit[IDX_HI]) |-> (prdata[REG_W-1:HI_W] == '0));
endmodule

// File: tb/tb_cipher_ctrl_regfile.sv
module tb_cipher_ctrl_regfile;
    localparam int ADDR_W = 12;
    localparam int HI_W   = 6;
    localparam int LO_W   = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic psel = 0, penable = 0, pwrite = 0;
    logic [ADDR_W-1:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic pready, pslverr;
    logic eng_done = 0, eng_alarm = 0, eng_bus_err = 0, eng_stream_act = 0, eng_busy = 0;
    logic fab_req = 0, fab_rel = 0;
    logic [LO_W-1:0] eng_addr = '0;
    logic eng_rst, eng_purge, eng_go, osc_on, stream_en, stall_en, fab_clk_sel;
    logic [1:0] stall_rate;
    logic [31:0] stall_seed;
    logic [HI_W+LO_W-1:0] master_addr;
    logic own_cpu, own_fab;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    cipher_ctrl_regfile #(.ADDR_W(ADDR_W), .HI_W(HI_W), .LO_W(LO_W)) dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
        .eng_done(eng_done), .eng_alarm(eng_alarm), .eng_bus_err(eng_bus_err),
        .eng_stream_act(eng_stream_act), .eng_busy(eng_busy),
        .fab_req(fab_req), .fab_rel(fab_rel), .eng_addr(eng_addr),
        .eng_rst(eng_rst), .eng_purge(eng_purge), .eng_go(eng_go), .osc_on(osc_on),
        .stream_en(stream_en), .stall_en(stall_en), .stall_rate(stall_rate),
        .fab_clk_sel(fab_clk_sel), .stall_seed(stall_seed), .master_addr(master_addr),
        .own_cpu(own_cpu), .own_fab(own_fab)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apb_write(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                             input logic fr, input logic fl);
        @(negedge clk);
        psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1; fab_req = fr; fab_rel = fl;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0; fab_req = 0; fab_rel = 0;
    endtask

    task automatic apb_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1; pwrite = 0; penable = 0; paddr = a;
        @(negedge clk);
        penable = 1;
        #1 d = prdata;
        @(negedge clk);
        psel = 0; penable = 0;
    endtask

    task automatic fab_pulse(input logic fr, input logic fl);
        @(negedge clk);
        fab_req = fr; fab_rel = fl;
        @(negedge clk);
        fab_req = 0; fab_rel = 0;
    endtask

    // Drive the arbiter to state s (0 free, 1 processor, 2 fabric)
    task automatic set_owner(input int s);
        fab_pulse(0, 1);
        apb_write(12'h000, 32'h0200_0000, 0, 0);
        if (s == 1) apb_write(12'h000, 32'h0100_0000, 0, 0);
        if (s == 2) fab_pulse(1, 0);
    endtask

    function automatic logic [31:0] ctrl_expect(input logic [8:0] v);
        return {15'b0, v[8], 8'b0, v[7:0]};
    endfunction

    // Watchdog: counts as a failed check and still reports
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        apb_read(12'h000, rd); check("R1 ctrl reset", rd, 32'h1);
        apb_read(12'h004, rd); check("R1 seed reset", rd, 0);
        apb_read(12'h008, rd); check("R1 hi reset", rd, 0);
        check("R1 outputs", {eng_rst, eng_purge, eng_go, osc_on, stream_en, stall_en,
                             stall_rate, fab_clk_sel, own_cpu, own_fab}, 11'b100_0000_0000);
        check("R9 pready/pslverr", {pready, pslverr}, 2'b10);

        // R2, R3: sweep every writable control pattern with reserved/RO bits set
        for (int v = 0; v < 512; v++) begin
            logic [8:0] f;
            f = 9'(v);
            apb_write(12'h000, ctrl_expect(f) | 32'hC0FE_FF00, 0, 0);
            apb_read(12'h000, rd);
            check("R2/R3 ctrl readback", rd, ctrl_expect(f));
            check("R2 ctrl outputs", {fab_clk_sel, stall_rate, stall_en, stream_en, osc_on,
                                      eng_go, eng_purge, eng_rst}, {f[8], f[7:0]});
        end

        // R3: status inputs visible at bits 12:8
        apb_write(12'h000, 32'h0, 0, 0);
        for (int s = 0; s < 32; s++) begin
            {eng_busy, eng_stream_act, eng_bus_err, eng_alarm, eng_done} = 5'(s);
            apb_read(12'h000, rd);
            check("R3 status bits", rd, 32'(s) << 8);
        end
        {eng_busy, eng_stream_act, eng_bus_err, eng_alarm, eng_done} = 5'b0;

        // R4: seed patterns
        for (int k = 0; k < 32; k++) begin
            logic [31:0] sv;
            sv = (32'h9E37_79B9 * 32'(k + 1)) ^ (32'h1 << k);
            apb_write(12'h004, sv, 0, 0);
            apb_read(12'h004, rd);
            check("R4 seed readback", rd, sv);
            check("R4 seed output", stall_seed, sv);
        end

        // R5: all upper-address values with upper write bits set
        for (int h = 0; h < 64; h++) begin
            eng_addr = 32'hA5A5_0000 + 32'(h * 257);
            apb_write(12'h008, 32'hFFFF_FFC0 | 32'(h), 0, 0);
            apb_read(12'h008, rd);
            check("R5 hi readback", rd, 32'(h));
            #1 check("R5 master_addr", master_addr, {6'(h), eng_addr});
        end

        // R9: unmapped and misaligned accesses
        apb_write(12'h004, 32'h1234_5678, 0, 0);
        apb_write(12'h00C, 32'hFFFF_FFFF, 0, 0);
        apb_write(12'h005, 32'hFFFF_FFFF, 0, 0);
        apb_write(12'h401, 32'hFFFF_FFFF, 0, 0);
        apb_read(12'h00C, rd); check("R9 unmapped read", rd, 0);
        apb_read(12'h002, rd); check("R9 misaligned read", rd, 0);
        apb_read(12'h004, rd); check("R9 seed untouched", rd, 32'h1234_5678);
        apb_read(12'h008, rd); check("R9 hi untouched", rd, 32'd63);
        apb_read(12'h000, rd); check("R9 ctrl untouched", rd, 32'h0);

        // R6, R7, R8: every start state against every request/release combination
        for (int s = 0; s < 3; s++) begin
            for (int c = 0; c < 16; c++) begin
                logic cr, cl, fr, fl;
                int nx;
                {fl, fr, cl, cr} = 4'(c);
                set_owner(s);
                apb_write(12'h000, {6'b0, cl, cr, 24'h0}, fr, fl);
                nx = s;
                if (s == 0)      nx = cr ? 1 : (fr ? 2 : 0);
                else if (s == 1) nx = cl ? 0 : 1;
                else             nx = fl ? 0 : 2;
                apb_read(12'h000, rd);
                check("R6/R7 owner readback", rd[29:24], {(nx == 2), (nx == 1), 4'b0});
                check("R8 owner outputs", {own_fab, own_cpu}, {(nx == 2), (nx == 1)});
            end
        end

        // R8: fabric inputs visible while processor holds the engine
        set_owner(1);
        @(negedge clk);
        psel = 1; pwrite = 0; penable = 0; paddr = '0; fab_req = 1; fab_rel = 1;
        @(negedge clk);
        penable = 1;
        #1 check("R8 fab inputs visible", prdata[29:24], 6'b011100);
        @(negedge clk);
        psel = 0; penable = 0; fab_req = 0; fab_rel = 0;
        check("R7 fabric ignored while processor owns", {own_fab, own_cpu}, 2'b01);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule